// File: doc/BRIEF.md
# Store-to-Load Data Forwarding Matcher

This combinational unit sits beside a load/store queue. The queue has already found an older store whose address matches a younger load. This unit takes the kind of that store, the kind of the load and the 64-bit data the store holds. It decides whether the store's data alone can produce the load's result. When it can, it returns that result at the load's width, with sign or zero extension as the load requires. When it cannot, the load has to wait for the cache.

The decision comes from an explicit table of store and load kinds. The table covers several cases:
- narrow integer stores feeding loads of the same width;
- a register-pair store feeding a pair load;
- float stores feeding float loads, and also feeding integer word loads by reinterpreting the bits;
- an atomic set-byte operation, whose forwarded value is always 255;
- a double-float store feeding an unsigned word load at either of its two word offsets.

Data is big-endian, so the first 32-bit word of a 64-bit value sits in bits 63:32. Narrow integer and single-float store data sits in the low bits of the store data.

Top module: `fwd_match`

## Requirements
- R1: A word store (storeKind 2) forwards to a signed word load (loadKind 4) as storeData[31:0] sign-extended to 64 bits. It forwards to an unsigned word load (5) or an alternate-space unsigned word load (6) as storeData[31:0] zero-extended. In all three cases fwdSize is 2 (word).
- R2: A word store (2) forwards to a single-float load (loadKind 8) as the raw storeData[31:0] with the upper 32 bits zero, and fwdSize is 2.
- R3: A register-pair store (storeKind 3) forwards only to a pair load (loadKind 7). The result is all 64 bits of storeData, and fwdSize is 3 (double).
- R4: A byte store (storeKind 0) forwards only to byte loads. A signed byte load (loadKind 0) gets storeData[7:0] sign-extended, and an unsigned byte load (1) gets it zero-extended. fwdSize is 0 (byte).
- R5: A halfword store (storeKind 1) forwards only to halfword loads. A signed halfword load (loadKind 2) gets storeData[15:0] sign-extended, and an unsigned halfword load (3) gets it zero-extended. fwdSize is 1 (half).
- R6: An atomic set-byte operation (storeKind 6) forwards only to an unsigned byte load (1). The result is the constant 255 whatever storeData holds, and fwdSize is 0.
- R7: A single-float store (storeKind 4) forwards to a single-float load (8) as raw storeData[31:0]. It forwards to a signed word load (4) as those bits sign-extended and to an unsigned word load (5) as those bits zero-extended. fwdSize is 2.
- R8: A double-float store (storeKind 5) forwards to a double-float load (loadKind 9) as all 64 bits, and fwdSize is 3.
- R9: A double-float store (5) forwards to an unsigned word load (5) at either word offset. With loadAtUpper=0 the result is storeData[63:32] zero-extended. With loadAtUpper=1, meaning the load address is the store address plus 4, the result is storeData[31:0] zero-extended. fwdSize is 2.
- R10: Every other combination reports no match, and then fwdData is 0 and fwdSize is 0. This includes storeKind 7, loadKind 10 to 15, and any pair other than the one in R9 with loadAtUpper=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| storeKind | input | 3 | Kind of the older store (encodings in R1 to R10) |
| loadKind | input | 4 | Kind of the younger load (encodings in R1 to R10) |
| loadAtUpper | input | 1 | 1 when the load address is the store address plus 4 |
| storeData | input | 64 | Data held by the store, big-endian |
| fwdHit | output | 1 | Store data can satisfy the load |
| fwdData | output | 64 | Forwarded, extended load result; zero on a miss |
| fwdSize | output | 2 | Result width: 0 byte, 1 half, 2 word, 3 double |

## Verification
The bench sweeps every combination of store kind, load kind and offset flag. Each combination is tried with four data patterns:
- All sign bits set in byte, half and word: this separates sign extension from zero extension.
- All sign bits clear: this shows that extension never invents ones.
- All ones: this catches a wrong lane on the constant set-byte result.
- Distinct upper and lower words: this tells apart which half of a double-float store reaches a word load.

Comparing every unlisted pair against zero output checks that no pair forwards by mistake.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int DATA_W = 64;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;
  localparam int SKIND_W = 3;
  localparam int LKIND_W = 4;

  localparam logic [SKIND_W-1:0] ST_BYTE = 3'd0;
  localparam logic [SKIND_W-1:0] ST_HALF = 3'd1;
  localparam logic [SKIND_W-1:0] ST_WORD = 3'd2;
  localparam logic [SKIND_W-1:0] ST_PAIR = 3'd3;
  localparam logic [SKIND_W-1:0] ST_SFLT = 3'd4;
  localparam logic [SKIND_W-1:0] ST_DFLT = 3'd5;
  localparam logic [SKIND_W-1:0] ST_SETB = 3'd6;

  localparam logic [LKIND_W-1:0] LD_SBYTE = 4'd0;
  localparam logic [LKIND_W-1:0] LD_UBYTE = 4'd1;
  localparam logic [LKIND_W-1:0] LD_SHALF = 4'd2;
  localparam logic [LKIND_W-1:0] LD_UHALF = 4'd3;
  localparam logic [LKIND_W-1:0] LD_SWORD = 4'd4;
  localparam logic [LKIND_W-1:0] LD_UWORD = 4'd5;
  localparam logic [LKIND_W-1:0] LD_UWALT = 4'd6;
  localparam logic [LKIND_W-1:0] LD_PAIR  = 4'd7;
  localparam logic [LKIND_W-1:0] LD_SFLT  = 4'd8;
  localparam logic [LKIND_W-1:0] LD_DFLT  = 4'd9;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DBL = 2'd3} size_e;
  typedef enum logic [1:0] {SRC_LOW, SRC_HIGH, SRC_FULL, SRC_ONES} src_e;

  typedef struct packed {
    logic  hit;
    size_e size;
    logic  signExt;
    src_e  src;
  } fwdCtrl_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  logic [SKIND_W-1:0] storeKind,
  input  logic [LKIND_W-1:0] loadKind,
  input  logic               loadAtUpper,
  output fwdCtrl_t           ctrl
);
  function automatic fwdCtrl_t mk(input size_e sz, input logic sx, input src_e s);
    fwdCtrl_t c;
    c.hit = 1'b1;
    c.size = sz;
    c.signExt = sx;
    c.src = s;
    return c;
  endfunction

  fwdCtrl_t aligned;

  always_comb begin
    aligned = '{hit: 1'b0, size: SZ_BYTE, signExt: 1'b0, src: SRC_LOW};
    case (storeKind)
      ST_BYTE: begin
        if (loadKind == LD_SBYTE) aligned = mk(SZ_BYTE, 1'b1, SRC_LOW);
        else if (loadKind == LD_UBYTE) aligned = mk(SZ_BYTE, 1'b0, SRC_LOW);
      end
      ST_HALF: begin
        if (loadKind == LD_SHALF) aligned = mk(SZ_HALF, 1'b1, SRC_LOW);
        else if (loadKind == LD_UHALF) aligned = mk(SZ_HALF, 1'b0, SRC_LOW);
      end
      ST_WORD: begin
        if (loadKind == LD_SWORD) aligned = mk(SZ_WORD, 1'b1, SRC_LOW);
        else if (loadKind == LD_UWORD || loadKind == LD_UWALT || loadKind == LD_SFLT)
          aligned = mk(SZ_WORD, 1'b0, SRC_LOW);
      end
      ST_PAIR: begin
        if (loadKind == LD_PAIR) aligned = mk(SZ_DBL, 1'b0, SRC_FULL);
      end
      ST_SFLT: begin
        if (loadKind == LD_SWORD) aligned = mk(SZ_WORD, 1'b1, SRC_LOW);
        else if (loadKind == LD_UWORD || loadKind == LD_SFLT) aligned = mk(SZ_WORD, 1'b0, SRC_LOW);
      end
      ST_DFLT: begin
        if (loadKind == LD_DFLT) aligned = mk(SZ_DBL, 1'b0, SRC_FULL);
        else if (loadKind == LD_UWORD) aligned = mk(SZ_WORD, 1'b0, SRC_HIGH);
      end
      ST_SETB: begin
        if (loadKind == LD_UBYTE) aligned = mk(SZ_BYTE, 1'b0, SRC_ONES);
      end
      default: ;
    endcase
  end

  // Offset 4 exists only for a word load from a double-float store; there
  // the second big-endian word is the lower half of the data.
  always_comb begin
    ctrl = aligned;
    if (loadAtUpper) begin
      if (storeKind == ST_DFLT && loadKind == LD_UWORD) ctrl.src = SRC_LOW;
      else ctrl = '{hit: 1'b0, size: SZ_BYTE, signExt: 1'b0, src: SRC_LOW};
    end
  end
endmodule

// File: rtl/fwd_data.sv
module fwd_data
  import fwd_pkg::*;
(
  input  fwdCtrl_t          ctrl,
  input  logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] fwdData,
  output logic [1:0]        fwdSize
);
  localparam logic [DATA_W-1:0] SETB_VALUE = DATA_W'({BYTE_W{1'b1}});

  logic [WORD_W-1:0] wordSel;
  logic [DATA_W-1:0] extended;

  always_comb begin
    wordSel = (ctrl.src == SRC_HIGH) ? storeData[DATA_W-1:WORD_W] : storeData[WORD_W-1:0];
    case (ctrl.size)
      SZ_BYTE: extended = {{(DATA_W-BYTE_W){ctrl.signExt & wordSel[BYTE_W-1]}}, wordSel[BYTE_W-1:0]};
      SZ_HALF: extended = {{(DATA_W-HALF_W){ctrl.signExt & wordSel[HALF_W-1]}}, wordSel[HALF_W-1:0]};
      SZ_WORD: extended = {{(DATA_W-WORD_W){ctrl.signExt & wordSel[WORD_W-1]}}, wordSel};
      default: extended = storeData;
    endcase
  end

  always_comb begin
    if (!ctrl.hit) begin
      fwdData = '0;
      fwdSize = SZ_BYTE;
    end else begin
      fwdData = (ctrl.src == SRC_ONES) ? SETB_VALUE :
                (ctrl.src == SRC_FULL) ? storeData : extended;
      fwdSize = ctrl.size;
    end
  end
endmodule

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
(
  input  logic [2:0]  storeKind,
  input  logic [3:0]  loadKind,
  input  logic        loadAtUpper,
  input  logic [63:0] storeData,
  output logic        fwdHit,
  output logic [63:0] fwdData,
  output logic [1:0]  fwdSize
);
  fwdCtrl_t ctrl;

  fwd_ctrl uCtrl (
    .storeKind(storeKind),
    .loadKind(loadKind),
    .loadAtUpper(loadAtUpper),
    .ctrl(ctrl)
  );

  fwd_data uData (
    .ctrl(ctrl),
    .storeData(storeData),
    .fwdData(fwdData),
    .fwdSize(fwdSize)
  );

  assign fwdHit = ctrl.hit;
endmodule

// File: rtl/fwd_match_chk.sv
module fwd_match_chk (
  input logic [2:0]  storeKind,
  input logic [3:0]  loadKind,
  input logic        loadAtUpper,
  input logic [63:0] storeData,
  input logic        fwdHit,
  input logic [63:0] fwdData,
  input logic [1:0]  fwdSize
);
  always_comb begin
    AST_MISS_IS_ZERO: assert (fwdHit || (fwdData == 64'd0 && fwdSize == 2'd0)); // R10
    AST_SETB_CONST: assert (!(fwdHit && storeKind == 3'd6) || fwdData == 64'd255); // R6
    AST_UBYTE_NARROW: assert (!(fwdHit && loadKind == 4'd1) || fwdData[63:8] == 56'd0); // R4
    AST_SWORD_EXT: assert (!(fwdHit && loadKind == 4'd4) || fwdData[63:32] == {32{fwdData[31]}}); // R1
    AST_DOUBLE_COPY: assert (!(fwdHit && fwdSize == 2'd3) || fwdData == storeData); // R3
    AST_UPPER_ONLY_DF: assert (!(fwdHit && loadAtUpper) || (storeKind == 3'd5 && loadKind == 4'd5)); // R9
  end
endmodule

bind fwd_match fwd_match_chk uChk (
  .storeKind(storeKind),
  .loadKind(loadKind),
  .loadAtUpper(loadAtUpper),
  .storeData(storeData),
  .fwdHit(fwdHit),
  .fwdData(fwdData),
  .fwdSize(fwdSize)
);

// File: tb/fwd_match_test.sv
module fwd_match_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  storeKind = 3'd7;
  logic [3:0]  loadKind = 4'd0;
  logic        loadAtUpper = 1'b0;
  logic [63:0] storeData = 64'd0;
  logic        fwdHit;
  logic [63:0] fwdData;
  logic [1:0]  fwdSize;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fwd_match uut (
    .storeKind(storeKind), .loadKind(loadKind), .loadAtUpper(loadAtUpper),
    .storeData(storeData), .fwdHit(fwdHit), .fwdData(fwdData), .fwdSize(fwdSize)
  );

  task automatic model(input int sk, input int lk, input int up, input logic [63:0] d,
                       output bit h, output logic [1:0] sz, output logic [63:0] r,
                       output string tag);
    h = 1'b0; sz = 2'd0; r = 64'd0; tag = "R10";
    if (up == 0) begin
      if (sk == 0 && lk == 0) begin h = 1; sz = 0; r = 64'($signed(d[7:0])); tag = "R4"; end
      if (sk == 0 && lk == 1) begin h = 1; sz = 0; r = 64'(d[7:0]); tag = "R4"; end
      if (sk == 1 && lk == 2) begin h = 1; sz = 1; r = 64'($signed(d[15:0])); tag = "R5"; end
      if (sk == 1 && lk == 3) begin h = 1; sz = 1; r = 64'(d[15:0]); tag = "R5"; end
      if (sk == 2 && lk == 4) begin h = 1; sz = 2; r = 64'($signed(d[31:0])); tag = "R1"; end
      if (sk == 2 && (lk == 5 || lk == 6)) begin h = 1; sz = 2; r = 64'(d[31:0]); tag = "R1"; end
      if (sk == 2 && lk == 8) begin h = 1; sz = 2; r = 64'(d[31:0]); tag = "R2"; end
      if (sk == 3 && lk == 7) begin h = 1; sz = 3; r = d; tag = "R3"; end
      if (sk == 4 && lk == 4) begin h = 1; sz = 2; r = 64'($signed(d[31:0])); tag = "R7"; end
      if (sk == 4 && (lk == 5 || lk == 8)) begin h = 1; sz = 2; r = 64'(d[31:0]); tag = "R7"; end
      if (sk == 5 && lk == 9) begin h = 1; sz = 3; r = d; tag = "R8"; end
      if (sk == 5 && lk == 5) begin h = 1; sz = 2; r = 64'(d[63:32]); tag = "R9"; end
      if (sk == 6 && lk == 1) begin h = 1; sz = 0; r = 64'd255; tag = "R6"; end
    end else if (sk == 5 && lk == 5) begin
      h = 1; sz = 2; r = 64'(d[31:0]); tag = "R9";
    end
  endtask

  task automatic check(input bit h, input logic [1:0] sz, input logic [63:0] r, input string tag);
    checks++;
    if (fwdHit !== h || fwdSize !== sz || fwdData !== r) begin
      errors++;
      $display("FAIL %s: store=%0d load=%0d up=%0d got hit=%0b size=%0d data=%h expected hit=%0b size=%0d data=%h",
               tag, storeKind, loadKind, loadAtUpper, fwdHit, fwdSize, fwdData, h, sz, r);
    end
  endtask

  initial begin
    logic [63:0] pats [4];
    bit h; logic [1:0] sz; logic [63:0] r; string tag;
    pats[0] = 64'h8123_4567_89AB_CDEF;
    pats[1] = 64'h7F00_0001_0000_7F7F;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h0123_4567_0000_0080;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(1'b0, 2'd0, 64'd0, "R10 idle");
    for (int p = 0; p < 4; p++)
      for (int sk = 0; sk < 8; sk++)
        for (int lk = 0; lk < 16; lk++)
          for (int up = 0; up < 2; up++) begin
            @(negedge clk);
            storeKind = 3'(sk); loadKind = 4'(lk); loadAtUpper = 1'(up); storeData = pats[p];
            #1;
            model(sk, lk, up, pats[p], h, sz, r, tag);
            check(h, sz, r, tag);
          end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule